// File: doc/BRIEF.md
# NTT-Domain Pairwise Polynomial Multiplier

This block multiplies two 256-coefficient polynomials that have already been taken into the number-theoretic-transform domain, modulo q = 3329. Operand coefficients come in over a valid/ready stream. Each transfer carries one coefficient of A and one of B, at the same index. Once all 256 indices are held, the block works through the 128 coefficient pairs. For each pair it applies a degree-one multiply, in which the cross term a1·b1 is scaled by a twiddle factor for that pair. It then sends out two reduced results over a second valid/ready stream.

Each pair is processed in three steps: a compute step with no output, a step that presents the even result, and a step that presents the odd result. As a result, every two output coefficients are separated by one idle cycle. When the last result has been taken, the block spends one cycle finishing up and then accepts the next operand pair. Callers are expected to supply coefficients that are already reduced, below 3329.

Top module: `ntt_pair_mul`

## Requirements
- R1: While rst_n is low, and at the first sample after reset, in_ready is 1 and out_valid is 0.
- R2: in_ready is high only while the block is waiting for or loading operands. Exactly 256 transfers are taken, and index k is the k-th accepted transfer, counting from 0. in_ready and out_valid are never high together.
- R3: Output number 2i is (a[2i]·b[2i] + a[2i+1]·b[2i+1]·z_i) mod 3329. Output number 2i+1 is (a[2i]·b[2i+1] + a[2i+1]·b[2i]) mod 3329. Outputs leave in increasing index order.
- R4: z_i = 17^(2·r+1) mod 3329, where r is the 7-bit index i with its bit order reversed (bit 0 becomes bit 6).
- R5: Every output coefficient lies in the range 0 to 3328.
- R6: out_valid is low for exactly one cycle before output 0, counted from the last operand transfer. It is low for exactly one cycle between outputs 2i+1 and 2i+2. It is never low between outputs 2i and 2i+1.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value on the next cycle.
- R8: In the cycle after the 256th output transfer, in_ready and out_valid are both 0. In the cycle after that, in_ready is 1.
- R9: in_valid has no effect while in_ready is low. Operand data offered during computation changes neither the current results nor the next polynomial that is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_coef | input | 12 | Coefficient of operand A |
| b_coef | input | 12 | Coefficient of operand B, same index as a_coef |
| in_valid | input | 1 | Operand transfer offered |
| in_ready | output | 1 | Block accepts an operand transfer |
| out_data | output | 12 | Result coefficient |
| out_valid | output | 1 | Result coefficient offered |
| out_ready | input | 1 | Consumer takes the result |

## Verification
A sequencer that slips by one state shows up at the ports straight away. It either breaks the single idle cycle between output pairs, or it swaps the even and odd results, so the first output pair after loading already mismatches. A wrong pair counter or wrong read addressing corrupts every output from that pair onward. A wrong twiddle entry corrupts only the even output of its own pair, which is why one test isolates each twiddle. A load counter that accepts data during computation is exposed by the next polynomial, because all of its later coefficients come out shifted.

// File: rtl/ntt_pm_pkg.sv
package ntt_pm_pkg;
  localparam int Q        = 3329;
  localparam int ZROOT    = 17;
  localparam int COEF_W   = 12;
  localparam int NCOEF    = 256;
  localparam int PAIRS    = NCOEF / 2;
  localparam int PAIR_W   = $clog2(PAIRS);
  localparam int BRT_K    = 24;
  localparam int BRT_M    = (1 << BRT_K) / Q;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_CALC, ST_OUT0, ST_OUT1, ST_DONE
  } pm_state_e;

  // Reduce x < 2^24 into [0, Q) with one quotient estimate and one correction.
  function automatic logic [COEF_W-1:0] barrett_red(input logic [23:0] x);
    logic [36:0] prod;
    logic [12:0] t;
    logic [24:0] r;
    prod = 37'(x) * 37'(BRT_M);
    t    = prod[36:24];
    r    = 25'(x) - 25'(t) * 25'(Q);
    if (r >= 25'(Q)) r = r - 25'(Q);
    return r[COEF_W-1:0];
  endfunction

  function automatic logic [COEF_W-1:0] mod_mul(input logic [COEF_W-1:0] a,
                                                input logic [COEF_W-1:0] b);
    return barrett_red(24'(a) * 24'(b));
  endfunction

  function automatic logic [COEF_W-1:0] mod_add(input logic [COEF_W-1:0] a,
                                                input logic [COEF_W-1:0] b);
    logic [12:0] s;
    s = 13'(a) + 13'(b);
    if (s >= 13'(Q)) s = s - 13'(Q);
    return s[COEF_W-1:0];
  endfunction

  // Elaboration-time twiddle: ZROOT^(2*bitrev(i)+1) mod Q
  function automatic logic [COEF_W-1:0] zeta_of(input int i);
    int br;
    int e;
    int z;
    br = 0;
    for (int k = 0; k < PAIR_W; k++)
      if (((i >> k) & 1) == 1) br = br | (1 << (PAIR_W - 1 - k));
    e = 2 * br + 1;
    z = 1;
    for (int k = 0; k < e; k++) z = (z * ZROOT) % Q;
    return COEF_W'(z);
  endfunction
endpackage

// File: rtl/ntt_pm_store.sv
module ntt_pm_store
  import ntt_pm_pkg::*;
#(
  parameter int N = NCOEF,
  parameter int W = COEF_W,
  localparam int AW = $clog2(N),
  localparam int PW = AW - 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wa,
  input  logic [W-1:0]  wb,
  input  logic [PW-1:0] rpair,
  output logic [W-1:0]  a0,
  output logic [W-1:0]  a1,
  output logic [W-1:0]  b0,
  output logic [W-1:0]  b1
);
  logic [W-1:0] mem_a [N];
  logic [W-1:0] mem_b [N];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_a[waddr] <= wa;
      mem_b[waddr] <= wb;
    end
  end

  assign a0 = mem_a[{rpair, 1'b0}];
  assign a1 = mem_a[{rpair, 1'b1}];
  assign b0 = mem_b[{rpair, 1'b0}];
  assign b1 = mem_b[{rpair, 1'b1}];
endmodule

// File: rtl/ntt_pm_twiddle.sv
module ntt_pm_twiddle
  import ntt_pm_pkg::*;
#(
  parameter int NP = PAIRS,
  localparam int PW = $clog2(NP)
) (
  input  logic [PW-1:0]     idx,
  output logic [COEF_W-1:0] zeta
);
  logic [COEF_W-1:0] tbl [NP];

  for (genvar g = 0; g < NP; g++) begin : g_tw
    localparam logic [COEF_W-1:0] ZV = zeta_of(g);
    assign tbl[g] = ZV;
  end

  assign zeta = tbl[idx];
endmodule

// File: rtl/ntt_pm_basemul.sv
module ntt_pm_basemul
  import ntt_pm_pkg::*;
(
  input  logic [COEF_W-1:0] a0,
  input  logic [COEF_W-1:0] a1,
  input  logic [COEF_W-1:0] b0,
  input  logic [COEF_W-1:0] b1,
  input  logic [COEF_W-1:0] zeta,
  output logic [COEF_W-1:0] c0,
  output logic [COEF_W-1:0] c1
);
  logic [COEF_W-1:0] p00, p11, p11z, p01, p10;

  always_comb begin
    p00  = mod_mul(a0, b0);
    p11  = mod_mul(a1, b1);
    p11z = mod_mul(p11, zeta);
    p01  = mod_mul(a0, b1);
    p10  = mod_mul(a1, b0);
    c0   = mod_add(p00, p11z);
    c1   = mod_add(p01, p10);
  end
endmodule

// File: rtl/ntt_pm_ctrl.sv
module ntt_pm_ctrl
  import ntt_pm_pkg::*;
#(
  parameter int N = NCOEF,
  localparam int AW = $clog2(N),
  localparam int PW = AW - 1,
  localparam int NP = N / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [PW-1:0] pair_idx,
  output logic          calc_en,
  output logic          sel_odd,
  output logic          odd_fire,
  output logic          last_fire
);
  pm_state_e state, state_nx;
  logic [AW-1:0] load_cnt;
  logic [PW-1:0] pair_cnt;
  logic          in_fire;
  logic          load_last;
  logic          pair_last;

  assign in_ready  = (state == ST_IDLE) || (state == ST_LOAD);
  assign out_valid = (state == ST_OUT0) || (state == ST_OUT1);
  assign in_fire   = in_valid && in_ready;
  assign load_last = load_cnt == AW'(N - 1);
  assign pair_last = pair_cnt == PW'(NP - 1);
  assign odd_fire  = (state == ST_OUT1) && out_ready;
  assign last_fire = odd_fire && pair_last;
  assign wr_en     = in_fire;
  assign wr_addr   = load_cnt;
  assign pair_idx  = pair_cnt;
  assign calc_en   = state == ST_CALC;
  assign sel_odd   = state == ST_OUT1;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (in_fire) state_nx = ST_LOAD;
      ST_LOAD: if (in_fire && load_last) state_nx = ST_CALC;
      ST_CALC: state_nx = ST_OUT0;
      ST_OUT0: if (out_ready) state_nx = ST_OUT1;
      ST_OUT1: if (out_ready) state_nx = pair_last ? ST_DONE : ST_CALC;
      ST_DONE: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      load_cnt <= '0;
      pair_cnt <= '0;
    end else begin
      state <= state_nx;
      if (in_fire) load_cnt <= load_last ? '0 : load_cnt + 1'b1;
      if (state == ST_IDLE) pair_cnt <= '0;
      else if (odd_fire) pair_cnt <= pair_last ? '0 : pair_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ntt_pair_mul.sv
module ntt_pair_mul
  import ntt_pm_pkg::*;
#(
  parameter int N = NCOEF,
  parameter int W = COEF_W,
  localparam int AW = $clog2(N),
  localparam int PW = AW - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_coef,
  input  logic [W-1:0] b_coef,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_ready
);
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [PW-1:0] pair_idx;
  logic          calc_en;
  logic          sel_odd;
  logic          odd_fire;
  logic          last_fire;
  logic [W-1:0]  a0, a1, b0, b1, zeta, c0, c1;
  logic [W-1:0]  c0_q, c1_q;

  ntt_pm_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .wr_en(wr_en),
    .wr_addr(wr_addr), .pair_idx(pair_idx), .calc_en(calc_en),
    .sel_odd(sel_odd), .odd_fire(odd_fire), .last_fire(last_fire)
  );

  ntt_pm_store #(.N(N), .W(W)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wa(a_coef), .wb(b_coef),
    .rpair(pair_idx), .a0(a0), .a1(a1), .b0(b0), .b1(b1)
  );

  ntt_pm_twiddle #(.NP(N / 2)) u_tw (
    .idx(pair_idx), .zeta(zeta)
  );

  ntt_pm_basemul u_mul (
    .a0(a0), .a1(a1), .b0(b0), .b1(b1), .zeta(zeta), .c0(c0), .c1(c1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_q <= '0;
      c1_q <= '0;
    end else if (calc_en) begin
      c0_q <= c0;
      c1_q <= c1;
    end
  end

  assign out_data = sel_odd ? c1_q : c0_q;
endmodule

// File: rtl/ntt_pm_chk.sv
module ntt_pm_chk
  import ntt_pm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [COEF_W-1:0] out_data,
  input logic              odd_fire,
  input logic              last_fire
);
  // R2
  stream_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R5
  range_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data < COEF_W'(Q)));

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  pair_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_fire && !last_fire) |=> !out_valid);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> (!in_ready && !out_valid));

  // R8
  done_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(last_fire, 2) |-> in_ready);
endmodule

bind ntt_pair_mul ntt_pm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .odd_fire(odd_fire),
  .last_fire(last_fire)
);

// File: tb/test_ntt_pair_mul.sv
module test_ntt_pair_mul;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 256;
  localparam int QM = 3329;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] a_coef, b_coef;
  logic        in_valid;
  logic        in_ready;
  logic [11:0] out_data;
  logic        out_valid;
  logic        out_ready;

  ntt_pair_mul i_ntt_pair_mul (
    .clk(clk), .rst_n(rst_n), .a_coef(a_coef), .b_coef(b_coef),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit timed_out = 1'b0;
  int a_v [NC];
  int b_v [NC];
  int got [NC];
  int out_idx = 0;
  int low_cnt = 0;
  bit collecting = 1'b0;
  int seed = 7;

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nxt();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return seed >>> 8;
  endfunction

  // Independent twiddle: 17^(2*reverse7(i)+1) mod q by repeated multiply (R4)
  function automatic int ref_zeta(input int i);
    int r = 0;
    int z = 1;
    for (int k = 0; k < 7; k++) r = (r << 1) | ((i >> k) & 1);
    for (int k = 0; k < 2 * r + 1; k++) z = (z * 17) % QM;
    return z;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    timed_out = 1'b1;
  end

  // Output collector: samples away from the active edge
  always @(negedge clk) begin
    if (collecting && out_idx < NC) begin
      if (out_valid && out_ready) begin
        got[out_idx] = int'(out_data);
        if (out_data >= 12'(QM)) chk("R5", int'(out_data), QM - 1, "range bound");
        chk("R6", low_cnt, (out_idx % 2 == 0) ? 1 : 0, $sformatf("idle cycles before out %0d", out_idx));
        out_idx++;
        low_cnt = 0;
      end else if (!out_valid) begin
        low_cnt++;
      end
    end
  end

  task automatic send_poly(input int gap_every, input int count);
    int i = 0;
    int cyc = 0;
    while (i < count && !timed_out) begin
      @(posedge clk); #1;
      cyc++;
      if (gap_every > 0 && (cyc % gap_every) == 0) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        a_coef = 12'(a_v[i]);
        b_coef = 12'(b_v[i]);
        @(negedge clk);
        if (in_ready) i++;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic collect(input bit bp, input bit junk);
    out_idx = 0;
    low_cnt = 0;
    collecting = 1'b1;
    while (out_idx < NC && !timed_out) begin
      if (junk) begin
        in_valid = 1'b1;
        a_coef = 12'(nxt() % QM);
        b_coef = 12'(nxt() % QM);
      end
      @(posedge clk); #1;
      if (bp) out_ready = (nxt() % 3) != 0;
    end
    collecting = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8", {31'd0, in_ready}, 0, "in_ready in finishing cycle");
    chk("R8", {31'd0, out_valid}, 0, "out_valid in finishing cycle");
    @(negedge clk);
    chk("R8", {31'd0, in_ready}, 1, "in_ready after finishing");
  endtask

  task automatic compare(input string tag);
    for (int p = 0; p < NC / 2; p++) begin
      int a0 = a_v[2*p];
      int a1 = a_v[2*p+1];
      int b0 = b_v[2*p];
      int b1 = b_v[2*p+1];
      int e0 = (a0 * b0 + ((a1 * b1) % QM) * ref_zeta(p)) % QM;
      int e1 = (a0 * b1 + a1 * b0) % QM;
      chk("R3", got[2*p], e0, $sformatf("%s out %0d", tag, 2*p));
      chk("R3", got[2*p+1], e1, $sformatf("%s out %0d", tag, 2*p+1));
    end
  endtask

  task automatic run_case(input string tag, input int gap_every, input bit bp, input bit junk);
    @(negedge clk);
    chk("R2", {31'd0, in_ready}, 1, {tag, " ready before load"});
    send_poly(gap_every, NC);
    collect(bp, junk);
    compare(tag);
  endtask

  task automatic t_zero();
    for (int i = 0; i < NC; i++) begin a_v[i] = 0; b_v[i] = 0; end
    run_case("zeros", 0, 1'b0, 1'b0);
  endtask

  task automatic t_random();
    for (int i = 0; i < NC; i++) begin a_v[i] = nxt() % QM; b_v[i] = nxt() % QM; end
    run_case("random", 0, 1'b0, 1'b0);
  endtask

  task automatic t_max();
    for (int i = 0; i < NC; i++) begin a_v[i] = QM - 1; b_v[i] = QM - 1; end
    run_case("max", 5, 1'b0, 1'b0);
  endtask

  // R4: isolate each twiddle, out 2i must equal z_i
  task automatic t_twiddle();
    for (int i = 0; i < NC; i++) begin
      a_v[i] = i % 2;
      b_v[i] = i % 2;
    end
    run_case("twiddle", 0, 1'b0, 1'b0);
    for (int p = 0; p < NC / 2; p++)
      chk("R4", got[2*p], ref_zeta(p), $sformatf("twiddle pair %0d", p));
  endtask

  // R7: random back-pressure on the output
  task automatic t_backpressure();
    for (int i = 0; i < NC; i++) begin a_v[i] = nxt() % QM; b_v[i] = nxt() % QM; end
    run_case("backpressure", 3, 1'b1, 1'b0);
  endtask

  // R9: junk offered while computing, then a clean polynomial
  task automatic t_ignore();
    for (int i = 0; i < NC; i++) begin a_v[i] = nxt() % QM; b_v[i] = nxt() % QM; end
    run_case("junk-during-compute R9", 0, 1'b0, 1'b1);
    for (int i = 0; i < NC; i++) begin a_v[i] = (i * 13 + 1) % QM; b_v[i] = (i * 29 + 5) % QM; end
    run_case("after-junk R9", 0, 1'b0, 1'b0);
  endtask

  // R1: reset in the middle of a load
  task automatic t_reset_mid();
    for (int i = 0; i < NC; i++) begin a_v[i] = nxt() % QM; b_v[i] = nxt() % QM; end
    send_poly(0, 100);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", {31'd0, in_ready}, 1, "in_ready during reset");
    chk("R1", {31'd0, out_valid}, 0, "out_valid during reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    run_case("after-reset", 0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    a_coef = '0;
    b_coef = '0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R1", {31'd0, in_ready}, 1, "in_ready in reset");
    chk("R1", {31'd0, out_valid}, 0, "out_valid in reset");
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {31'd0, out_valid}, 0, "out_valid after reset");
    t_zero();
    t_random();
    t_max();
    t_twiddle();
    t_backpressure();
    t_ignore();
    t_reset_mid();
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule